// File: doc/BRIEF.md
# I2C Master Byte Sequencer

This block is the byte-level control engine of an I2C master. Software, or a register front end, pushes 11-bit command words into a transmit command queue. Each word either writes one data byte or asks for one byte to be read. Two flag bits in the word can also request a STOP after that byte, or a repeated START with a fresh address phase before it. The sequencer takes commands from the queue and turns them into single bus operations: START, repeated START, write byte, read byte and STOP. It hands each operation to a bit-level bus engine through a valid/done handshake.

Addresses come from a target register that selects 7-bit or 10-bit addressing. Received bytes are placed in a receive queue. If the queue runs dry before a STOP has been asked for, the sequencer keeps the bus claimed and waits.

Every failure ends in an abort. The cause is recorded as a one-hot code, both queues are emptied and a sticky abort flag is raised. A NACK abort also releases the bus with a STOP. The enable input takes effect only between transfers.

Top module: `i2c_cmd_sequencer`

## Requirements
- R1: After reset, both queue levels are 0 and `busActive`, `enableStatus`, `opValid`, `abortIrq`, `stopIrq` and `abortSource` are all 0.
- R2: A command word holds the data byte in bits 7:0. Bit 8 = 1 asks for a read, bit 8 = 0 asks for a write. A write is issued as `opCode` 2 (WRITE) with `opByte` equal to bits 7:0.
- R3: With target bit 12 clear, a transfer starts with `opCode` 0 (START). The START is followed by a WRITE of the address byte {target[6:0], R/W}, where R/W is 1 for a read.
- R4: With target bit 12 set, the address phase is START, then {5'b11110, target[9:8], 0}, then target[7:0]. For a read, it continues with `opCode` 1 (RESTART) and then {5'b11110, target[9:8], 1}.
- R5: Command bit 9 issues `opCode` 4 (STOP) after that byte. When the STOP completes, `stopIrq` is set and `busActive` returns to 0.
- R6: Command bit 10 issues a RESTART plus a new address phase before that byte. A change of direction from the previous command does the same.
- R7: A read is issued as `opCode` 3 (READ). `opAck` is 1, except when the read command also carries bit 9, where it is 0. Received bytes leave the receive queue in arrival order.
- R8: When the command queue is empty and no STOP has been requested, `busActive` stays 1 and no operation is issued until a new command arrives.
- R9: A NACK sets `abortSource` to exactly one bit: bit 0 for a 7-bit address, bit 1 for the first 10-bit address byte, bit 2 for the second 10-bit address byte, or bit 3 for a data byte. It also sets `abortIrq`, empties both queues and issues a STOP.
- R10: Lost arbitration sets `abortSource` to bit 12 and empties both queues. The block then returns to idle without issuing a STOP.
- R11: A push while `enableStatus` is 0 is discarded, sets `abortSource` to bit 11 and sets `abortIrq`.
- R12: `enableStatus` follows `enableReq` only while idle. A disable request during a transfer takes effect after that transfer's STOP.
- R13: `txLevel` and `rxLevel` give the number of entries held in each queue at all times.
- R14: `abortClr` clears `abortIrq` and `abortSource`. `stopClr` clears `stopIrq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enableReq | input | 1 | Requested enable state |
| enableStatus | output | 1 | Enable state in effect |
| cmdPush | input | 1 | Push `cmdWord` into the command queue |
| cmdWord | input | 11 | Command word |
| cmdFull | output | 1 | Command queue full |
| txLevel | output | $clog2(CMD_DEPTH+1) | Command queue fill level |
| rxPop | input | 1 | Pop the receive queue head |
| rxData | output | 8 | Receive queue head |
| rxLevel | output | $clog2(RX_DEPTH+1) | Receive queue fill level |
| rxEmpty | output | 1 | Receive queue empty |
| tarWrite | input | 1 | Load the target register |
| tarValue | input | 13 | Target address; bit 12 selects 10-bit mode |
| busActive | output | 1 | Transfer in progress |
| abortSource | output | 13 | One-hot abort cause |
| abortIrq | output | 1 | Sticky abort flag |
| abortClr | input | 1 | Clear abort flag and cause |
| stopIrq | output | 1 | Sticky STOP-completed flag |
| stopClr | input | 1 | Clear STOP flag |
| opValid | output | 1 | Bus operation requested |
| opCode | output | 3 | 0 START, 1 RESTART, 2 WRITE, 3 READ, 4 STOP |
| opByte | output | 8 | Byte to send for WRITE |
| opAck | output | 1 | Acknowledge to return for READ |
| opDone | input | 1 | Operation finished (one-cycle pulse) |
| opNack | input | 1 | Slave did not acknowledge, valid with `opDone` |
| opArbLost | input | 1 | Arbitration lost, valid with `opDone` |
| opRdData | input | 8 | Byte read, valid with `opDone` |

## Verification
The bench drives several kinds of transfer through a model of the bus engine that logs every operation: plain 7-bit writes, 7-bit reads, 10-bit reads, and mixed sequences with an explicit repeated START and an implied one from a change of direction. Comparing these operation logs shows whether the address byte is formed correctly, when a RESTART is inserted, and whether the last read is answered with NACK. Separate patterns stall the queue in the middle of a transfer and inject a NACK at each address and data position. Further patterns lose arbitration and push while the block is disabled. Together these tell apart the abort codes, the STOP-versus-no-STOP exits and the flush of each queue.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  localparam int CMD_W = 11;
  localparam int TAR_W = 13;
  localparam int ABORT_W = 13;

  localparam int CMD_READ_BIT = 8;
  localparam int CMD_STOP_BIT = 9;
  localparam int CMD_RESTART_BIT = 10;
  localparam int TAR_TEN_BIT = 12;

  localparam int ABT_ADDR7 = 0;
  localparam int ABT_TEN_HI = 1;
  localparam int ABT_TEN_LO = 2;
  localparam int ABT_DATA = 3;
  localparam int ABT_DISABLED = 11;
  localparam int ABT_ARB = 12;

  typedef enum logic [2:0] {
    OP_START   = 3'd0,
    OP_RESTART = 3'd1,
    OP_WRITE   = 3'd2,
    OP_READ    = 3'd3,
    OP_STOP    = 3'd4
  } bus_op_e;

  typedef struct packed {
    logic               cmdPop;
    logic               rxPush;
    logic [7:0]         rxByte;
    logic               flush;
    logic               setAbort;
    logic [ABORT_W-1:0] abortCode;
    logic               setStop;
  } seq_strobe_t;
endpackage

// File: rtl/i2c_seq_fifo.sv
module i2c_seq_fifo #(
  parameter int W = 8,
  parameter int DEPTH = 8,
  parameter int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  pushData,
  input  logic          pop,
  output logic [W-1:0]  headData,
  output logic          empty,
  output logic          full,
  output logic [LW-1:0] level
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rdPtr, wrPtr;
  logic [LW-1:0] count;
  logic          doPush, doPop;

  assign empty    = (count == '0);
  assign full     = (count == LW'(DEPTH));
  assign level    = count;
  assign headData = mem[rdPtr];
  assign doPush   = push && !full;
  assign doPop    = pop && !empty;

  always_ff @(posedge clk) begin
    if (doPush && !flush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else if (flush) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (count == '0)); // R9
endmodule

// File: rtl/i2c_seq_datapath.sv
module i2c_seq_datapath import i2c_seq_pkg::*; #(
  parameter int CMD_DEPTH = 8,
  parameter int RX_DEPTH = 8,
  parameter int TXL_W = $clog2(CMD_DEPTH + 1),
  parameter int RXL_W = $clog2(RX_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enableStatus,
  input  seq_strobe_t        strb,
  input  logic               cmdPush,
  input  logic [CMD_W-1:0]   cmdWord,
  output logic [CMD_W-1:0]   cmdHead,
  output logic               cmdEmpty,
  output logic               cmdFull,
  output logic [TXL_W-1:0]   txLevel,
  input  logic               rxPop,
  output logic [7:0]         rxData,
  output logic               rxEmpty,
  output logic [RXL_W-1:0]   rxLevel,
  input  logic               tarWrite,
  input  logic [TAR_W-1:0]   tarValue,
  output logic [TAR_W-1:0]   tarReg,
  input  logic               abortClr,
  input  logic               stopClr,
  output logic [ABORT_W-1:0] abortSource,
  output logic               abortIrq,
  output logic               stopIrq
);
  logic rxFull;
  logic cmdAccept;

  assign cmdAccept = cmdPush && enableStatus;

  i2c_seq_fifo #(.W(CMD_W), .DEPTH(CMD_DEPTH), .LW(TXL_W)) u_cmdQ (
    .clk(clk), .rstN(rstN), .flush(strb.flush),
    .push(cmdAccept), .pushData(cmdWord), .pop(strb.cmdPop),
    .headData(cmdHead), .empty(cmdEmpty), .full(cmdFull), .level(txLevel)
  );

  i2c_seq_fifo #(.W(8), .DEPTH(RX_DEPTH), .LW(RXL_W)) u_rxQ (
    .clk(clk), .rstN(rstN), .flush(strb.flush),
    .push(strb.rxPush), .pushData(strb.rxByte), .pop(rxPop),
    .headData(rxData), .empty(rxEmpty), .full(rxFull), .level(rxLevel)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tarReg      <= '0;
      abortSource <= '0;
      abortIrq    <= 1'b0;
      stopIrq     <= 1'b0;
    end else begin
      if (tarWrite) tarReg <= tarValue;
      if (strb.setAbort) begin
        abortSource <= strb.abortCode;
        abortIrq    <= 1'b1;
      end else if (abortClr) begin
        abortSource <= '0;
        abortIrq    <= 1'b0;
      end
      if (strb.setStop)  stopIrq <= 1'b1;
      else if (stopClr)  stopIrq <= 1'b0;
    end
  end

  AST_DISABLED_PUSH_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    (cmdPush && !enableStatus) |=> (txLevel == '0 && abortIrq)); // R11
  AST_STOP_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    strb.setStop |=> stopIrq); // R5
  AST_ABORT_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    strb.setAbort |=> (abortIrq && $countones(abortSource) == 1)); // R9
  AST_RX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strb.rxPush |-> !rxFull); // R7
endmodule

// File: rtl/i2c_seq_control.sv
module i2c_seq_control import i2c_seq_pkg::*; (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enableReq,
  input  logic             cmdPush,
  input  logic             cmdEmpty,
  input  logic [CMD_W-1:0] cmdHead,
  input  logic [TAR_W-1:0] tarReg,
  output logic             enableStatus,
  output logic             busActive,
  output logic             opValid,
  output bus_op_e          opCode,
  output logic [7:0]       opByte,
  output logic             opAck,
  input  logic             opDone,
  input  logic             opNack,
  input  logic             opArbLost,
  input  logic [7:0]       opRdData,
  output seq_strobe_t      strb
);
  typedef enum logic [3:0] {
    ST_IDLE, ST_FETCH, ST_START, ST_RESTART, ST_ADDR_HI,
    ST_ADDR_LO, ST_RS10, ST_ADDR_RD, ST_DATA, ST_STOP
  } seq_state_e;

  seq_state_e       state, stateNext;
  logic [CMD_W-1:0] curCmd;
  logic             loadCmd;
  logic             tenBit, isRead, wantStop;

  assign tenBit    = tarReg[TAR_TEN_BIT];
  assign isRead    = curCmd[CMD_READ_BIT];
  assign wantStop  = curCmd[CMD_STOP_BIT];
  assign busActive = (state != ST_IDLE);
  assign opAck     = !wantStop;

  function automatic logic [ABORT_W-1:0] abortBit(input int pos);
    return ABORT_W'(1) << pos;
  endfunction

  // operation presented to the bus engine
  always_comb begin
    opValid = 1'b1;
    opCode  = OP_WRITE;
    opByte  = curCmd[7:0];
    case (state)
      ST_START:            opCode = OP_START;
      ST_RESTART, ST_RS10: opCode = OP_RESTART;
      ST_ADDR_HI: opByte = tenBit ? {5'b11110, tarReg[9:8], 1'b0}
                                  : {tarReg[6:0], isRead};
      ST_ADDR_LO: opByte = tarReg[7:0];
      ST_ADDR_RD: opByte = {5'b11110, tarReg[9:8], 1'b1};
      ST_DATA:    opCode = isRead ? OP_READ : OP_WRITE;
      ST_STOP:    opCode = OP_STOP;
      default:    opValid = 1'b0;
    endcase
  end

  // sequencing and strobes toward the datapath
  always_comb begin
    stateNext   = state;
    loadCmd     = 1'b0;
    strb        = '0;
    strb.rxByte = opRdData;
    case (state)
      ST_IDLE: begin
        if (enableStatus && enableReq && !cmdEmpty) begin
          strb.cmdPop = 1'b1;
          loadCmd     = 1'b1;
          stateNext   = ST_START;
        end
      end
      ST_FETCH: begin
        if (!cmdEmpty) begin
          strb.cmdPop = 1'b1;
          loadCmd     = 1'b1;
          if (cmdHead[CMD_RESTART_BIT] || (cmdHead[CMD_READ_BIT] != isRead))
            stateNext = ST_RESTART;
          else
            stateNext = ST_DATA;
        end
      end
      ST_START, ST_RESTART: if (opDone) stateNext = ST_ADDR_HI;
      ST_ADDR_HI: begin
        if (opDone) begin
          if (opNack) begin
            strb.setAbort  = 1'b1;
            strb.abortCode = abortBit(tenBit ? ABT_TEN_HI : ABT_ADDR7);
            strb.flush     = 1'b1;
            stateNext      = ST_STOP;
          end else begin
            stateNext = tenBit ? ST_ADDR_LO : ST_DATA;
          end
        end
      end
      ST_ADDR_LO: begin
        if (opDone) begin
          if (opNack) begin
            strb.setAbort  = 1'b1;
            strb.abortCode = abortBit(ABT_TEN_LO);
            strb.flush     = 1'b1;
            stateNext      = ST_STOP;
          end else begin
            stateNext = isRead ? ST_RS10 : ST_DATA;
          end
        end
      end
      ST_RS10: if (opDone) stateNext = ST_ADDR_RD;
      ST_ADDR_RD: begin
        if (opDone) begin
          if (opNack) begin
            strb.setAbort  = 1'b1;
            strb.abortCode = abortBit(ABT_TEN_HI);
            strb.flush     = 1'b1;
            stateNext      = ST_STOP;
          end else begin
            stateNext = ST_DATA;
          end
        end
      end
      ST_DATA: begin
        if (opDone) begin
          if (isRead) begin
            strb.rxPush = 1'b1;
            stateNext   = wantStop ? ST_STOP : ST_FETCH;
          end else if (opNack) begin
            strb.setAbort  = 1'b1;
            strb.abortCode = abortBit(ABT_DATA);
            strb.flush     = 1'b1;
            stateNext      = ST_STOP;
          end else begin
            stateNext = wantStop ? ST_STOP : ST_FETCH;
          end
        end
      end
      ST_STOP: begin
        if (opDone) begin
          strb.setStop = 1'b1;
          stateNext    = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase

    if (opValid && opDone && opArbLost) begin
      strb.rxPush    = 1'b0;
      strb.setStop   = 1'b0;
      strb.setAbort  = 1'b1;
      strb.abortCode = abortBit(ABT_ARB);
      strb.flush     = 1'b1;
      stateNext      = ST_IDLE;
    end

    if (cmdPush && !enableStatus) begin
      strb.setAbort  = 1'b1;
      strb.abortCode = abortBit(ABT_DISABLED);
      strb.flush     = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      curCmd       <= '0;
      enableStatus <= 1'b0;
    end else begin
      state <= stateNext;
      if (loadCmd) curCmd <= cmdHead;
      if (state == ST_IDLE) enableStatus <= enableReq;
    end
  end

  AST_NACK_FLUSHES_QUEUE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA && opDone && opNack && !isRead) |=> cmdEmpty); // R9
  AST_HOLD_KEEPS_BUS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FETCH && cmdEmpty) |=> (busActive && !opValid)); // R8
  AST_ENABLE_STABLE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busActive && $past(busActive)) |-> $stable(enableStatus)); // R12
  AST_STOP_ENDS_XFER: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_STOP && opDone) |=> !busActive); // R5
endmodule

// File: rtl/i2c_cmd_sequencer.sv
module i2c_cmd_sequencer import i2c_seq_pkg::*; #(
  parameter int CMD_DEPTH = 8,
  parameter int RX_DEPTH = 8,
  parameter int TXL_W = $clog2(CMD_DEPTH + 1),
  parameter int RXL_W = $clog2(RX_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enableReq,
  output logic               enableStatus,
  input  logic               cmdPush,
  input  logic [CMD_W-1:0]   cmdWord,
  output logic               cmdFull,
  output logic [TXL_W-1:0]   txLevel,
  input  logic               rxPop,
  output logic [7:0]         rxData,
  output logic [RXL_W-1:0]   rxLevel,
  output logic               rxEmpty,
  input  logic               tarWrite,
  input  logic [TAR_W-1:0]   tarValue,
  output logic               busActive,
  output logic [ABORT_W-1:0] abortSource,
  output logic               abortIrq,
  input  logic               abortClr,
  output logic               stopIrq,
  input  logic               stopClr,
  output logic               opValid,
  output logic [2:0]         opCode,
  output logic [7:0]         opByte,
  output logic               opAck,
  input  logic               opDone,
  input  logic               opNack,
  input  logic               opArbLost,
  input  logic [7:0]         opRdData
);
  seq_strobe_t      strb;
  logic [CMD_W-1:0] cmdHead;
  logic             cmdEmpty;
  logic [TAR_W-1:0] tarReg;
  bus_op_e          opCodeE;

  assign opCode = opCodeE;

  i2c_seq_control u_ctrl (
    .clk(clk), .rstN(rstN), .enableReq(enableReq), .cmdPush(cmdPush),
    .cmdEmpty(cmdEmpty), .cmdHead(cmdHead), .tarReg(tarReg),
    .enableStatus(enableStatus), .busActive(busActive),
    .opValid(opValid), .opCode(opCodeE), .opByte(opByte), .opAck(opAck),
    .opDone(opDone), .opNack(opNack), .opArbLost(opArbLost),
    .opRdData(opRdData), .strb(strb)
  );

  i2c_seq_datapath #(
    .CMD_DEPTH(CMD_DEPTH), .RX_DEPTH(RX_DEPTH), .TXL_W(TXL_W), .RXL_W(RXL_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .enableStatus(enableStatus), .strb(strb),
    .cmdPush(cmdPush), .cmdWord(cmdWord), .cmdHead(cmdHead),
    .cmdEmpty(cmdEmpty), .cmdFull(cmdFull), .txLevel(txLevel),
    .rxPop(rxPop), .rxData(rxData), .rxEmpty(rxEmpty), .rxLevel(rxLevel),
    .tarWrite(tarWrite), .tarValue(tarValue), .tarReg(tarReg),
    .abortClr(abortClr), .stopClr(stopClr), .abortSource(abortSource),
    .abortIrq(abortIrq), .stopIrq(stopIrq)
  );
endmodule

// File: tb/i2c_cmd_sequencer_tb.sv
`timescale 1ns/1ps
module i2c_cmd_sequencer_tb;
  localparam int OPS = 0, OPR = 1, OPW = 2, OPRD = 3, OPP = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic enableReq = 1'b0, cmdPush = 1'b0, rxPop = 1'b0, tarWrite = 1'b0;
  logic abortClr = 1'b0, stopClr = 1'b0;
  logic [10:0] cmdWord = '0;
  logic [12:0] tarValue = '0;
  logic opDone = 1'b0, opNack = 1'b0, opArbLost = 1'b0;
  logic [7:0] opRdData = '0;
  logic enableStatus, cmdFull, rxEmpty, busActive, abortIrq, stopIrq;
  logic opValid, opAck;
  logic [3:0] txLevel, rxLevel;
  logic [7:0] rxData, opByte;
  logic [12:0] abortSource;
  logic [2:0] opCode;

  int checks = 0, errors = 0, cycles = 0;
  int logOp [64];
  int logByte [64];
  int logAck [64];
  int logCount = 0, nackAt = -1, arbAt = -1, rdCnt = 0;
  int engCnt = 0, engIdx = 0, engOp = 0;
  bit engBusy = 0;

  i2c_cmd_sequencer u_dut (
    .clk(clk), .rstN(rstN), .enableReq(enableReq), .enableStatus(enableStatus),
    .cmdPush(cmdPush), .cmdWord(cmdWord), .cmdFull(cmdFull), .txLevel(txLevel),
    .rxPop(rxPop), .rxData(rxData), .rxLevel(rxLevel), .rxEmpty(rxEmpty),
    .tarWrite(tarWrite), .tarValue(tarValue), .busActive(busActive),
    .abortSource(abortSource), .abortIrq(abortIrq), .abortClr(abortClr),
    .stopIrq(stopIrq), .stopClr(stopClr), .opValid(opValid), .opCode(opCode),
    .opByte(opByte), .opAck(opAck), .opDone(opDone), .opNack(opNack),
    .opArbLost(opArbLost), .opRdData(opRdData)
  );

  always #2 clk = ~clk;

  // bus engine model: takes an operation, answers two cycles later
  always @(negedge clk) begin
    if (!rstN) begin
      opDone = 0; engBusy = 0;
    end else if (opDone) begin
      opDone = 0; opNack = 0; opArbLost = 0;
    end else if (engBusy) begin
      engCnt--;
      if (engCnt == 0) begin
        engBusy = 0;
        opDone = 1;
        opNack = (engIdx == nackAt);
        opArbLost = (engIdx == arbAt);
        if (engOp == OPRD) begin
          opRdData = 8'h5A + 8'(rdCnt);
          rdCnt++;
        end
      end
    end else if (opValid) begin
      engBusy = 1; engCnt = 2; engOp = int'(opCode); engIdx = logCount;
      logOp[logCount] = int'(opCode);
      logByte[logCount] = int'(opByte);
      logAck[logCount] = int'(opAck);
      if (logCount < 63) logCount++;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic chkOp(input string req, input int idx, input int op, input int b);
    chk(req, $sformatf("op[%0d] code", idx), logOp[idx], op);
    if (b >= 0) chk(req, $sformatf("op[%0d] byte", idx), logByte[idx], b);
  endtask

  task automatic clearLog();
    logCount = 0; nackAt = -1; arbAt = -1; rdCnt = 0;
  endtask

  task automatic push(input logic [10:0] w);
    @(negedge clk); cmdPush = 1; cmdWord = w;
    @(negedge clk); cmdPush = 0;
  endtask

  task automatic setTar(input logic [12:0] t);
    @(negedge clk); tarWrite = 1; tarValue = t;
    @(negedge clk); tarWrite = 0;
  endtask

  task automatic waitIdle();
    int n = 0;
    repeat (3) @(negedge clk);
    while (busActive && n < 2000) begin @(negedge clk); n++; end
    if (busActive) chk("R5", "idle timeout", 1, 0);
  endtask

  task automatic clearFlags();
    @(negedge clk); abortClr = 1; stopClr = 1;
    @(negedge clk); abortClr = 0; stopClr = 0;
  endtask

  task automatic testReset();
    chk("R1", "txLevel", txLevel, 0);
    chk("R1", "rxLevel", rxLevel, 0);
    chk("R1", "busActive", busActive, 0);
    chk("R1", "enableStatus", enableStatus, 0);
    chk("R1", "opValid", opValid, 0);
    chk("R1", "irqs", {abortIrq, stopIrq}, 0);
    chk("R1", "abortSource", abortSource, 0);
  endtask

  task automatic testWrite7();
    clearLog();
    setTar(13'h050);
    push(11'h011); push(11'h022); push(11'h233);
    chk("R13", "txLevel after three pushes", txLevel, 2);
    waitIdle();
    chk("R2", "op count", logCount, 6);
    chkOp("R3", 0, OPS, -1);
    chkOp("R3", 1, OPW, 8'hA0);
    chkOp("R2", 2, OPW, 8'h11);
    chkOp("R2", 3, OPW, 8'h22);
    chkOp("R2", 4, OPW, 8'h33);
    chkOp("R5", 5, OPP, -1);
    chk("R5", "stopIrq", stopIrq, 1);
    chk("R5", "busActive", busActive, 0);
    clearFlags();
    chk("R14", "stopIrq cleared", stopIrq, 0);
  endtask

  task automatic testRead7();
    clearLog();
    push(11'h100); push(11'h300);
    waitIdle();
    chkOp("R3", 1, OPW, 8'hA1);
    chkOp("R7", 2, OPRD, -1);
    chk("R7", "ack first read", logAck[2], 1);
    chkOp("R7", 3, OPRD, -1);
    chk("R7", "nack last read", logAck[3], 0);
    chkOp("R5", 4, OPP, -1);
    chk("R13", "rxLevel", rxLevel, 2);
    chk("R7", "first byte", rxData, 8'h5A);
    @(negedge clk); rxPop = 1; @(negedge clk); rxPop = 0;
    chk("R13", "rxLevel after pop", rxLevel, 1);
    chk("R7", "second byte", rxData, 8'h5B);
    @(negedge clk); rxPop = 1; @(negedge clk); rxPop = 0;
    chk("R7", "rxEmpty", rxEmpty, 1);
    clearFlags();
  endtask

  task automatic testRestart();
    clearLog();
    push(11'h044); push(11'h455); push(11'h300);
    waitIdle();
    chk("R6", "op count", logCount, 10);
    chkOp("R6", 2, OPW, 8'h44);
    chkOp("R6", 3, OPR, -1);
    chkOp("R6", 4, OPW, 8'hA0);
    chkOp("R6", 5, OPW, 8'h55);
    chkOp("R6", 6, OPR, -1);
    chkOp("R6", 7, OPW, 8'hA1);
    chkOp("R6", 8, OPRD, -1);
    chkOp("R6", 9, OPP, -1);
    @(negedge clk); rxPop = 1; @(negedge clk); rxPop = 0;
    clearFlags();
  endtask

  task automatic testTenBitRead();
    clearLog();
    setTar(13'h12C5);
    push(11'h300);
    waitIdle();
    chk("R4", "op count", logCount, 7);
    chkOp("R4", 0, OPS, -1);
    chkOp("R4", 1, OPW, 8'hF4);
    chkOp("R4", 2, OPW, 8'hC5);
    chkOp("R4", 3, OPR, -1);
    chkOp("R4", 4, OPW, 8'hF5);
    chkOp("R4", 5, OPRD, -1);
    chkOp("R4", 6, OPP, -1);
    chk("R4", "read byte", rxData, 8'h5A);
    @(negedge clk); rxPop = 1; @(negedge clk); rxPop = 0;
    setTar(13'h050);
    clearFlags();
  endtask

  task automatic testHold();
    clearLog();
    push(11'h066);
    repeat (30) @(negedge clk);
    chk("R8", "busActive while held", busActive, 1);
    chk("R8", "ops while held", logCount, 3);
    chk("R8", "opValid while held", opValid, 0);
    push(11'h277);
    waitIdle();
    chkOp("R8", 3, OPW, 8'h77);
    chkOp("R8", 4, OPP, -1);
    clearFlags();
  endtask

  task automatic testDataNack();
    clearLog();
    push(11'h300);
    waitIdle();
    chk("R13", "rx byte left", rxLevel, 1);
    clearLog();
    nackAt = 2;
    push(11'h011); push(11'h022); push(11'h233);
    waitIdle();
    chk("R9", "abortSource data", abortSource, 13'h0008);
    chk("R9", "abortIrq", abortIrq, 1);
    chk("R9", "txLevel flushed", txLevel, 0);
    chk("R9", "rxLevel flushed", rxLevel, 0);
    chk("R9", "op count", logCount, 4);
    chkOp("R9", 3, OPP, -1);
    clearFlags();
    chk("R14", "abortSource cleared", abortSource, 0);
    chk("R14", "abortIrq cleared", abortIrq, 0);
  endtask

  task automatic testAddrNack();
    for (int k = 0; k < 3; k++) begin
      clearLog();
      setTar(k == 0 ? 13'h050 : 13'h12C5);
      nackAt = (k == 2) ? 2 : 1;
      push(11'h211);
      waitIdle();
      chk("R9", $sformatf("addr abort case %0d", k), abortSource, 13'h1 << k);
      chkOp("R9", nackAt + 1, OPP, -1);
      clearFlags();
    end
    setTar(13'h050);
  endtask

  task automatic testArbLost();
    clearLog();
    arbAt = 1;
    push(11'h011); push(11'h022); push(11'h233);
    waitIdle();
    chk("R10", "abortSource arb", abortSource, 13'h1000);
    chk("R10", "no stop issued", logCount, 2);
    chk("R10", "stopIrq", stopIrq, 0);
    chk("R10", "txLevel flushed", txLevel, 0);
    clearFlags();
  endtask

  task automatic testDisabledPush();
    clearLog();
    @(negedge clk); enableReq = 0;
    repeat (3) @(negedge clk);
    chk("R12", "enableStatus off", enableStatus, 0);
    push(11'h011);
    repeat (5) @(negedge clk);
    chk("R11", "abortSource disabled", abortSource, 13'h0800);
    chk("R11", "abortIrq", abortIrq, 1);
    chk("R11", "txLevel", txLevel, 0);
    chk("R11", "no ops", logCount, 0);
    clearFlags();
  endtask

  task automatic testDisableMidXfer();
    clearLog();
    @(negedge clk); enableReq = 1;
    repeat (3) @(negedge clk);
    chk("R12", "enableStatus on", enableStatus, 1);
    push(11'h012);
    repeat (20) @(negedge clk);
    @(negedge clk); enableReq = 0;
    repeat (10) @(negedge clk);
    chk("R12", "enable held during transfer", enableStatus, 1);
    push(11'h234);
    waitIdle();
    repeat (2) @(negedge clk);
    chk("R12", "enableStatus after transfer", enableStatus, 0);
    chkOp("R12", 3, OPW, 8'h34);
    clearFlags();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1;
    @(negedge clk); enableReq = 1;
    repeat (3) @(negedge clk);
    testWrite7();
    testRead7();
    testRestart();
    testTenBitRead();
    testHold();
    testDataNack();
    testAddrNack();
    testArbLost();
    testDisabledPush();
    testDisableMidXfer();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule